// File: doc/BRIEF.md
# Rank-Wide Activate and Refresh Limiter

This block sits beside a memory controller's command scheduler and enforces the timing rules that span every bank of a rank. It watches the command issued each cycle and keeps three kinds of state: a short gap that must follow every row activate, a record of the four most recent activates, and blackout windows that follow a refresh or a precharge of all banks. From that state it drives two flags that tell the scheduler whether an activate or a refresh may issue in the current cycle.

All spacing values arrive on configuration inputs and are counted in controller clock cycles. The activate history stores the cycle stamp of each activate, taken from a free-running counter. Subtraction with wrap handles counter rollover, and entries old enough to no longer matter are retired before the counter can alias them. If the scheduler issues a command whose flag is low, the block raises a one-cycle violation flag and leaves all of its timing state as it was.

Top module: `rank_act_guard`

## Requirements
- R1: After an accepted activate, `act_ok` stays low until `cfg_rrd` cycles have passed. An activate accepted in cycle t allows the next one from cycle t+`cfg_rrd`. A value of 0 or 1 means no extra gap.
- R2: Within any span of `cfg_faw` cycles, at most four activates are accepted. A fifth activate is allowed only once the oldest of the last four is at least `cfg_faw` cycles old.
- R3: After an accepted refresh in cycle t, both `act_ok` and `ref_ok` stay low until cycle t+`cfg_rfc`.
- R4: After a precharge-all in cycle t, `act_ok` stays low until cycle t+`cfg_pa2act`.
- R5: After a precharge-all in cycle t, `ref_ok` stays low until cycle t+`cfg_pa2ref`.
- R6: An activate presented while `act_ok` is low, or a refresh presented while `ref_ok` is low, raises `viol` for exactly the next cycle and changes no timing state.
- R7: After a synchronous active-low reset, `act_ok` and `ref_ok` are high, `viol` is low, and the activate history is empty. Four back-to-back activates are then allowed.
- R8: An activate history entry never blocks again after a long idle period, even when the cycle counter has wrapped many times.
- R9: `cmd_kind` encodes 2'b00 as no limited command, 2'b01 as activate, 2'b10 as refresh and 2'b11 as precharge-all. Code 2'b00 changes no timing state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_kind | input | 2 | Command issued this cycle (encoding in R9) |
| cfg_rrd | input | TW | Minimum activate-to-activate gap |
| cfg_faw | input | TW | Four-activate window length |
| cfg_rfc | input | TW | Refresh blackout length |
| cfg_pa2act | input | TW | Precharge-all to activate delay |
| cfg_pa2ref | input | TW | Precharge-all to refresh delay |
| act_ok | output | 1 | An activate may issue this cycle |
| ref_ok | output | 1 | A refresh may issue this cycle |
| viol | output | 1 | A blocked command was presented in the previous cycle |

## Verification
The assertions check every cycle that an accepted activate, refresh or precharge-all closes the matching flag on the next cycle, and that the window only refuses activates while all four history slots are live. Only the bench scenarios can show the exact cycle each flag reopens, that the fifth activate waits for the oldest stamp, that a refused command leaves the timers untouched, that reset empties the history, and that stamps cannot alias after the cycle counter wraps during a long idle period.

// File: rtl/rlim_pkg.sv
// Shared command encoding for the rank-wide limiter.
// Assumes the scheduler presents at most one command per cycle.
package rlim_pkg;
    typedef enum logic [1:0] {
        CK_NONE = 2'b00,
        CK_ACT  = 2'b01,
        CK_REF  = 2'b10,
        CK_PALL = 2'b11
    } cmd_kind_e;
endpackage

// File: rtl/rlim_span_timer.sv
// Countdown blackout timer. On load, it holds busy for len cycles counted
// from the loading cycle; a shorter reload never cuts a running span.
// Assumes len is stable in the loading cycle only.
module rlim_span_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          busy
);
    logic [TW-1:0] cnt;
    logic [TW-1:0] nxt_load;
    logic [TW-1:0] nxt_dec;

    // Candidate values: freshly loaded span and aged current span.
    always_comb begin
        nxt_load = (len == '0) ? '0 : len - 1'b1;
        nxt_dec  = (cnt == '0) ? '0 : cnt - 1'b1;
    end

    // Keep whichever span ends later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load && (nxt_load > nxt_dec))
            cnt <= nxt_load;
        else
            cnt <= nxt_dec;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/rlim_act_window.sv
// Rolling record of the last NACT activate cycle stamps. It grants room for
// a new activate when the slot about to be overwritten (the oldest) is empty
// or at least faw_len cycles old. Stamps use a counter one bit wider than
// the timing values; a live entry is retired once its age reaches 2**TW, so
// wrap-around can never make an old stamp look young.
module rlim_act_window #(
    parameter int TW   = 8,
    parameter int NACT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [TW-1:0] faw_len,
    output logic          room
);
    localparam int CW = TW + 1;
    localparam int PW = (NACT > 1) ? $clog2(NACT) : 1;

    logic [CW-1:0] now;
    logic [CW-1:0] stamp [NACT];
    logic [CW-1:0] age   [NACT];
    logic [NACT-1:0] live;
    logic [PW-1:0] ptr;

    // Free-running cycle counter used for stamps.
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end

    // Wrap-safe age of each slot.
    for (genvar g = 0; g < NACT; g++) begin : g_age
        assign age[g] = now - stamp[g];
    end

    // Oldest slot decides whether another activate fits.
    assign room = !live[ptr] || (age[ptr] >= {1'b0, faw_len});

    // Record accepted activates, retire aged-out slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
            ptr  <= '0;
            for (int i = 0; i < NACT; i++) stamp[i] <= '0;
        end else begin
            for (int i = 0; i < NACT; i++)
                if (live[i] && age[i][CW-1]) live[i] <= 1'b0;
            if (take) begin
                stamp[ptr] <= now;
                live[ptr]  <= 1'b1;
                ptr        <= (ptr == PW'(NACT-1)) ? '0 : ptr + 1'b1;
            end
        end
    end

    // R2
    full_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !room |-> (&live));
endmodule

// File: rtl/rank_act_guard.sv
// Rank-wide limiter for activates and refreshes. It combines the
// activate-to-activate gap, the four-activate window, the refresh blackout
// and both precharge-all delays into two permission flags. It assumes the
// scheduler drives cmd_kind once per cycle; refused commands only raise viol.
module rank_act_guard #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd_kind,
    input  logic [TW-1:0] cfg_rrd,
    input  logic [TW-1:0] cfg_faw,
    input  logic [TW-1:0] cfg_rfc,
    input  logic [TW-1:0] cfg_pa2act,
    input  logic [TW-1:0] cfg_pa2ref,
    output logic          act_ok,
    output logic          ref_ok,
    output logic          viol
);
    import rlim_pkg::*;

    cmd_kind_e kind;
    logic is_act, is_ref, is_pall;
    logic act_take, ref_take;
    logic rrd_busy, rfc_busy, pa_act_busy, pa_ref_busy, faw_room;
    logic viol_q;

    // Decode the command and qualify it against the flags.
    always_comb begin
        kind     = cmd_kind_e'(cmd_kind);
        is_act   = (kind == CK_ACT);
        is_ref   = (kind == CK_REF);
        is_pall  = (kind == CK_PALL);
        act_take = is_act && act_ok;
        ref_take = is_ref && ref_ok;
    end

    rlim_span_timer #(.TW(TW)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(act_take), .len(cfg_rrd), .busy(rrd_busy));
    rlim_span_timer #(.TW(TW)) u_rfc (
        .clk(clk), .rst_n(rst_n), .load(ref_take), .len(cfg_rfc), .busy(rfc_busy));
    rlim_span_timer #(.TW(TW)) u_pa_act (
        .clk(clk), .rst_n(rst_n), .load(is_pall), .len(cfg_pa2act), .busy(pa_act_busy));
    rlim_span_timer #(.TW(TW)) u_pa_ref (
        .clk(clk), .rst_n(rst_n), .load(is_pall), .len(cfg_pa2ref), .busy(pa_ref_busy));

    rlim_act_window #(.TW(TW), .NACT(4)) u_win (
        .clk(clk), .rst_n(rst_n), .take(act_take), .faw_len(cfg_faw), .room(faw_room));

    // Permission flags from all constraint sources.
    assign act_ok = !rrd_busy && !rfc_busy && !pa_act_busy && faw_room;
    assign ref_ok = !rfc_busy && !pa_ref_busy;

    // One-cycle flag for a command presented against a low permission.
    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= (is_act && !act_ok) || (is_ref && !ref_ok);
    end
    assign viol = viol_q;

    // R1
    rrd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_take && cfg_rrd > 1) |=> !act_ok);
    // R3
    rfc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_take && cfg_rfc > 1) |=> (!act_ok && !ref_ok));
    // R4
    pall_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pall && cfg_pa2act > 1) |=> !act_ok);
    // R5
    pall_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pall && cfg_pa2ref > 1) |=> !ref_ok);
endmodule

// File: tb/sim_rank_act_guard.sv
`timescale 1ns/1ps
module sim_rank_act_guard;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cmd_kind = 2'b00;
    logic [TW-1:0] cfg_rrd = 8'd2, cfg_faw = 8'd10, cfg_rfc = 8'd5;
    logic [TW-1:0] cfg_pa2act = 8'd3, cfg_pa2ref = 8'd4;
    logic act_ok, ref_ok, viol;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rank_act_guard #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind),
        .cfg_rrd(cfg_rrd), .cfg_faw(cfg_faw), .cfg_rfc(cfg_rfc),
        .cfg_pa2act(cfg_pa2act), .cfg_pa2ref(cfg_pa2ref),
        .act_ok(act_ok), .ref_ok(ref_ok), .viol(viol));

    // Fields: {req[3:0], cmd[1:0], exp_act, exp_ref, exp_viol}
    // Expectations are sampled before the step's command takes effect.
    localparam logic [8:0] VEC [24] = '{
        {4'd7, 2'b00, 3'b110},  // 0 reset state
        {4'd9, 2'b01, 3'b110},  // 1 ACT at t1
        {4'd1, 2'b01, 3'b010},  // 2 ACT refused by gap
        {4'd6, 2'b01, 3'b111},  // 3 viol from 2, ACT at t3
        {4'd1, 2'b00, 3'b010},  // 4
        {4'd1, 2'b01, 3'b110},  // 5 ACT at t5
        {4'd1, 2'b00, 3'b010},  // 6
        {4'd2, 2'b01, 3'b110},  // 7 ACT at t7, window full
        {4'd1, 2'b00, 3'b010},  // 8
        {4'd2, 2'b01, 3'b010},  // 9 ACT refused by window
        {4'd2, 2'b00, 3'b011},  // 10 oldest still 9 cycles old
        {4'd2, 2'b01, 3'b110},  // 11 oldest 10 cycles old, ACT
        {4'd1, 2'b00, 3'b010},  // 12
        {4'd3, 2'b10, 3'b110},  // 13 REF
        {4'd3, 2'b00, 3'b000},  // 14
        {4'd3, 2'b00, 3'b000},  // 15
        {4'd3, 2'b00, 3'b000},  // 16
        {4'd6, 2'b01, 3'b000},  // 17 ACT refused in blackout
        {4'd3, 2'b00, 3'b111},  // 18 blackout over, viol from 17
        {4'd4, 2'b11, 3'b110},  // 19 PREALL
        {4'd4, 2'b00, 3'b000},  // 20
        {4'd5, 2'b10, 3'b000},  // 21 REF refused
        {4'd4, 2'b00, 3'b101},  // 22 ACT reopens
        {4'd5, 2'b00, 3'b110}   // 23 REF reopens
    };

    function automatic string rtag(input int r);
        case (r)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] k);
        @(negedge clk);
        cmd_kind = k;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmd_kind = 2'b00;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // Table walk
        for (int i = 0; i < 24; i++) begin
            string t;
            t = rtag(int'(VEC[i][8:5]));
            step(VEC[i][4:3]);
            chk(t, "act_ok", act_ok, VEC[i][2]);
            chk(t, "ref_ok", ref_ok, VEC[i][1]);
            chk(t, "viol", viol, VEC[i][0]);
        end

        // R7: reset empties a freshly filled window
        step(2'b00);
        cfg_rrd = 8'd1;
        for (int i = 0; i < 4; i++) step(2'b01);
        do_reset();
        #1;
        chk("R7", "act_ok after reset", act_ok, 1'b1);
        chk("R7", "ref_ok after reset", ref_ok, 1'b1);
        chk("R7", "viol after reset", viol, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(2'b01);
            chk("R7", "back-to-back ACT", act_ok, 1'b1);
        end
        step(2'b00);
        chk("R2", "fifth ACT in window", act_ok, 1'b0);

        // R8: long idle across counter wrap, long window
        do_reset();
        cfg_faw = 8'd200;
        for (int i = 0; i < 4; i++) step(2'b01);
        step(2'b00);
        chk("R2", "window full, faw 200", act_ok, 1'b0);
        for (int i = 0; i < 600; i++) step(2'b00);
        chk("R8", "ACT after long idle", act_ok, 1'b1);
        chk("R9", "idle leaves REF open", ref_ok, 1'b1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule